// File: doc/BRIEF.md
# Serial DAC Word Shifter

This block feeds 18-bit samples to a serial-input digital-to-analog converter over three wires: a bit clock, a data line and a latch enable. A sample arrives in parallel through a valid/ready handshake. The block then sends it MSB first, one bit per bit-clock period. The bit clock is the system clock divided by a parameter. After the LSB it raises latch enable for one bit period and then lowers it. The falling edge moves the shifted word into the converter's output register. Data and latch enable change only while the bit clock is low, so they are steady at the rising edge where the converter samples them.

A mode input picks one of two clocking styles. In continuous mode the bit clock runs all the time, and while idle the data line sits low. In stopped mode the bit clock rests low between words. Latch enable then stays low from its falling edge, through the idle gap and the whole next word, so at least one full bit-clock cycle of the new word passes before it rises again. A one-cycle done pulse marks each latch.

Top module: `dac_word_tx`

## Requirements
- R1: While rst_ni is low and in the first cycle after its release, dac_bclk_o, dac_data_o, dac_le_o and done_o are 0 and smp_ready_o is 1.
- R2: Each word is sent as WORD_W bit slots, bit WORD_W-1 first and bit 0 last. Each slot lasts 2*HALF_DIV system cycles. dac_data_o changes only while dac_bclk_o is low.
- R3: While the bit clock runs, each high phase and each low phase lasts exactly HALF_DIV system cycles. Elaboration fails if HALF_DIV*SYS_CLK_NS does not exceed both MIN_PHASE_NS and MIN_SETUP_NS.
- R4: Right after the LSB slot, dac_le_o is high for exactly one slot (2*HALF_DIV cycles) with dac_data_o low. It then falls on a bit-clock falling edge.
- R5: After its fall, dac_le_o stays low for one more full slot before the block becomes idle. done_o is high for exactly the one cycle in which dac_le_o falls.
- R6: smp_ready_o is 1 only when no word is waiting or in flight. A sample is taken on a cycle where smp_valid_i and smp_ready_o are both 1. smp_valid_i has no effect while smp_ready_o is 0.
- R7: With stop_mode_i = 0 the bit clock toggles even while idle, and dac_data_o and dac_le_o stay low. An accepted word begins at the first bit-clock falling edge after acceptance.
- R8: With stop_mode_i = 1 the bit clock stays low while idle. An accepted word begins one cycle after acceptance with a full low phase. dac_le_o does not rise again until at least WORD_W bit-clock rising edges have occurred since its last fall.
- R9: smp_ready_o returns the cycle after the post-latch slot ends. In stopped mode, a word offered at once then gives done pulses spaced (WORD_W+2)*2*HALF_DIV+2 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_mode_i | input | 1 | 1: bit clock rests between words; 0: bit clock runs continuously |
| smp_data_i | input | WORD_W | Parallel sample |
| smp_valid_i | input | 1 | Sample valid |
| smp_ready_o | output | 1 | Block can take a sample |
| dac_bclk_o | output | 1 | Bit clock to converter |
| dac_data_o | output | 1 | Serial data, MSB first |
| dac_le_o | output | 1 | Latch enable; its falling edge transfers the word |
| done_o | output | 1 | One-cycle pulse when latch enable falls |

## Verification
The hardest case to reach is the continuous-mode start. There an acceptance can land on any phase of the free-running bit clock, and the word must wait for the next falling edge. The stimulus offers words after idle gaps of different lengths, so acceptances fall on many phase offsets. The behavioural model checks each of these starts cycle by cycle. A second shift register in the bench, clocked only by the emitted bit clock, rebuilds each word as the converter would see it. It also counts bit-clock edges while latch enable is low, which checks the stopped-mode hold rule across mode changes.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;
  typedef enum logic [1:0] {
    SLOT_BIT    = 2'd0,
    SLOT_LE_HI  = 2'd1,
    SLOT_LE_LO  = 2'd2
  } slot_kind_e;
endpackage

// File: rtl/dac_bclk_gen.sv
module dac_bclk_gen #(
  parameter int unsigned HALF_DIV = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic bclk_o,
  output logic tick_o,
  output logic ph_zero_o
);
  localparam int unsigned PERIOD = 2 * HALF_DIV;
  localparam int unsigned PW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [PW-1:0] ph_q;

  assign tick_o    = (ph_q == PW'(PERIOD - 1));
  assign bclk_o    = (ph_q >= PW'(HALF_DIV));
  assign ph_zero_o = (ph_q == '0);

  // phase parks at zero (bit clock low) when not running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ph_q <= '0;
    else if (!run_i)       ph_q <= '0;
    else if (tick_o)       ph_q <= '0;
    else                   ph_q <= ph_q + 1'b1;
  end
endmodule

// File: rtl/dac_word_seq.sv
module dac_word_seq
  import dac_tx_pkg::*;
#(
  parameter int unsigned WORD_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stop_i,
  input  logic              tick_i,
  input  logic              ph_zero_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic              data_o,
  output logic              le_o,
  output logic              done_o
);
  localparam int unsigned SLOTS = WORD_W + 2;
  localparam int unsigned SW    = $clog2(SLOTS + 1);

  logic              armed_q, busy_q;
  logic [SW-1:0]     slot_q;
  logic [WORD_W-1:0] sreg_q;
  logic              accept, start, last_slot;
  slot_kind_e        kind;

  assign ready_o   = !busy_q && !armed_q;
  assign accept    = valid_i && ready_o;
  // stopped mode: clock is parked at phase zero, start at once
  assign start     = armed_q && (stop_i || tick_i);
  assign last_slot = (slot_q == SW'(SLOTS - 1));

  always_comb begin
    if (slot_q < SW'(WORD_W))       kind = SLOT_BIT;
    else if (slot_q == SW'(WORD_W)) kind = SLOT_LE_HI;
    else                            kind = SLOT_LE_LO;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      busy_q  <= 1'b0;
      slot_q  <= '0;
      sreg_q  <= '0;
    end else begin
      if (accept) begin
        armed_q <= 1'b1;
        sreg_q  <= data_i;
      end
      if (start) begin
        armed_q <= 1'b0;
        busy_q  <= 1'b1;
        slot_q  <= '0;
      end else if (busy_q && tick_i) begin
        if (last_slot) begin
          busy_q <= 1'b0;
          slot_q <= '0;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
        sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign busy_o = busy_q;
  assign data_o = busy_q && (kind == SLOT_BIT) && sreg_q[WORD_W-1];
  assign le_o   = busy_q && (kind == SLOT_LE_HI);
  assign done_o = busy_q && (kind == SLOT_LE_LO) && ph_zero_i;
endmodule

// File: rtl/dac_word_tx.sv
module dac_word_tx #(
  parameter int unsigned WORD_W       = 18,
  parameter int unsigned HALF_DIV     = 5,
  parameter int unsigned SYS_CLK_NS   = 10,
  parameter int unsigned MIN_PHASE_NS = 40,
  parameter int unsigned MIN_SETUP_NS = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stop_mode_i,
  input  logic [WORD_W-1:0] smp_data_i,
  input  logic              smp_valid_i,
  output logic              smp_ready_o,
  output logic              dac_bclk_o,
  output logic              dac_data_o,
  output logic              dac_le_o,
  output logic              done_o
);
  localparam int unsigned PHASE_NS = HALF_DIV * SYS_CLK_NS;

  generate
    if (HALF_DIV == 0 || PHASE_NS <= MIN_PHASE_NS || PHASE_NS <= MIN_SETUP_NS) begin : g_bad_div
      $error("dac_word_tx: bit clock phase too short for converter timing");
    end
  endgenerate

  logic busy, tick, ph_zero, run;

  assign run = !stop_mode_i || busy;

  dac_bclk_gen #(.HALF_DIV(HALF_DIV)) u_bclk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .bclk_o   (dac_bclk_o),
    .tick_o   (tick),
    .ph_zero_o(ph_zero)
  );

  dac_word_seq #(.WORD_W(WORD_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stop_i   (stop_mode_i),
    .tick_i   (tick),
    .ph_zero_i(ph_zero),
    .valid_i  (smp_valid_i),
    .data_i   (smp_data_i),
    .ready_o  (smp_ready_o),
    .busy_o   (busy),
    .data_o   (dac_data_o),
    .le_o     (dac_le_o),
    .done_o   (done_o)
  );
endmodule

// File: rtl/dac_word_tx_chk.sv
module dac_word_tx_chk #(
  parameter int unsigned HALF_DIV = 5
) (
  input logic clk_i,
  input logic rst_ni,
  input logic stop_mode_i,
  input logic smp_ready_o,
  input logic dac_bclk_o,
  input logic dac_data_o,
  input logic dac_le_o,
  input logic done_o
);
  int unsigned hi_len, le_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_len <= 0;
      le_len <= 0;
    end else begin
      hi_len <= dac_bclk_o ? hi_len + 1 : 0;
      le_len <= dac_le_o   ? le_len + 1 : 0;
    end
  end

  a_r3_high_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dac_bclk_o) |-> hi_len == HALF_DIV);

  a_r2_data_moves_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dac_data_o) |-> !dac_bclk_o);

  a_r4_le_moves_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dac_le_o) |-> !dac_bclk_o);

  a_r4_le_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_le_o |-> !dac_data_o);

  a_r4_le_one_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dac_le_o) |-> le_len == 2 * HALF_DIV);

  a_r5_done_at_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dac_le_o) |-> done_o);

  a_r5_done_only_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $fell(dac_le_o));

  a_r6_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_ready_o |-> !dac_le_o && !dac_data_o);

  a_r8_stop_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_mode_i && $past(stop_mode_i) && smp_ready_o && $past(smp_ready_o) |-> !dac_bclk_o);
endmodule

bind dac_word_tx dac_word_tx_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stop_mode_i(stop_mode_i),
  .smp_ready_o(smp_ready_o),
  .dac_bclk_o (dac_bclk_o),
  .dac_data_o (dac_data_o),
  .dac_le_o   (dac_le_o),
  .done_o     (done_o)
);

// File: tb/test_dac_word_tx.sv
module test_dac_word_tx;
  localparam int W  = 18;
  localparam int H  = 5;
  localparam int P  = 2 * H;
  localparam int SL = W + 2;

  logic clk = 1'b0, rst_n = 1'b0, stop = 1'b0, valid = 1'b0;
  logic [W-1:0] din = '0;
  logic ready, bclk, data, le, done;

  always #5 clk = ~clk;

  dac_word_tx i_dac_word_tx (
    .clk_i(clk), .rst_ni(rst_n), .stop_mode_i(stop),
    .smp_data_i(din), .smp_valid_i(valid), .smp_ready_o(ready),
    .dac_bclk_o(bclk), .dac_data_o(data), .dac_le_o(le), .done_o(done)
  );

  int n_run = 0, n_fail = 0, cyc = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // behavioural reference
  int m_ph = 0, m_off = 0;
  bit m_act = 0, m_pend = 0;
  logic [W-1:0] m_word = '0, m_next = '0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_off = 0; m_act = 0; m_pend = 0;
    end else begin
      bit acc, tck, run;
      acc = valid && !m_act && !m_pend;
      tck = (m_ph == P - 1);
      run = !stop || m_act;
      if (m_act) begin
        m_off++;
        if (m_off == SL * P) m_act = 0;
      end else if (m_pend && (stop || tck)) begin
        m_act = 1; m_off = 0; m_pend = 0; m_word = m_next;
      end
      if (acc) begin m_pend = 1; m_next = din; end
      m_ph = run ? (m_ph + 1) % P : 0;
    end
    if (cyc > 60000) begin
      n_fail++;
      $display("FAIL R6 watchdog: actual %0d cycles expected below 60000", cyc);
      summary();
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int sl, ph;
      sl = m_off / P; ph = m_off % P;
      chk("R3 bclk", bclk, m_ph >= H);
      chk("R2 data", data, (m_act && sl < W) ? m_word[W-1-sl] : 1'b0);
      chk("R4 le",   le,   m_act && sl == W);
      chk("R5 done", done, m_act && sl == W + 1 && ph == 0);
      chk("R6 R9 ready", ready, !m_act && !m_pend);
    end
  end

  // converter-side view
  logic [W-1:0] cap = '0;
  logic [W-1:0] exp_q[$];
  int rises_lo = 0, n_latch = 0, n_sent = 0;
  int done_t[$];

  always @(posedge bclk) begin
    if (!le) begin cap = {cap[W-2:0], data}; rises_lo++; end
  end
  always @(posedge le) begin
    chk("R8 le low rises", rises_lo >= W, 1);
  end
  always @(negedge le) begin
    n_latch++;
    rises_lo = 0;
    if (exp_q.size() > 0) chk("R2 latched word", cap, exp_q.pop_front());
  end
  always @(negedge clk) if (rst_n && done) done_t.push_back(cyc);

  task automatic send(logic [W-1:0] w);
    @(negedge clk);
    while (!ready) @(negedge clk);
    valid = 1'b1; din = w;
    exp_q.push_back(w); n_sent++;
    @(negedge clk);
    valid = 1'b0; din = '0;
  endtask

  task automatic poke_busy(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1'b1; din = 18'h15A5A ^ W'(i);
    end
    @(negedge clk);
    valid = 1'b0; din = '0;
  endtask

  task automatic idle_rises(int n, output int r);
    logic prev;
    r = 0;
    prev = bclk;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (bclk && !prev) r++;
      prev = bclk;
    end
  endtask

  initial begin
    int r, t0;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 bclk", bclk, 0);  chk("R1 data", data, 0);
    chk("R1 le", le, 0);      chk("R1 done", done, 0);
    chk("R1 ready", ready, 1);
    rst_n = 1'b1;

    // R7: continuous mode, idle clock runs, then words at varied phases
    idle_rises(4 * P, r);
    chk("R7 idle rises", r, 4);
    send(18'h2AAAA);
    poke_busy(5);              // R6: ignored while busy
    send(18'h3FFFF);
    repeat (3) @(negedge clk);
    send(18'h00001);
    repeat (7) @(negedge clk);
    send(18'h12345);

    // R8: stopped mode, idle clock parked low
    wait (ready);
    @(negedge clk);
    stop = 1'b1;
    repeat (2) @(negedge clk);
    idle_rises(4 * P, r);
    chk("R8 idle rises", r, 0);
    send(18'h20000);
    repeat (13) @(negedge clk);
    send(18'h1ABCD);
    // R9: back-to-back spacing in stopped mode
    send(18'h0F0F0);
    t0 = done_t.size();
    wait (ready);
    repeat (3 * P) @(negedge clk);
    chk("R9 done spacing", done_t[done_t.size()-1] - done_t[done_t.size()-2], SL * P + 2);
    if (t0 == 0) chk("R9 done seen", 0, 1);

    // back to continuous
    stop = 1'b0;
    send(18'h3C3C3);
    wait (ready);
    repeat (3 * P) @(negedge clk);
    chk("R6 words latched", n_latch, n_sent);
    chk("R2 queue drained", exp_q.size(), 0);
    summary();
  end
endmodule